// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is one parallel I/O port of a microcontroller, NPINS wide (eight pins by default), controlled from a small synchronous register bus. Software sets the direction of each pin and the level it drives. The block turns those two bits into three controls for each pad: an output enable, an output value and a pull-up enable. A global pull-up-off input can switch off the pull-ups on every pin at once.

Software reads the pad levels through a pin-sample register. Each pad input passes through a latch that is open while the clock is low, and then through a flip-flop that captures on the rising edge. This filters out metastability, at the cost of read latency. The bus write to the pin-sample address has a second use: every one bit written there inverts the matching output-data bit. This gives single-bit toggling without a read-modify-write.

The block applies each write exactly as given. It inserts no intermediate pad states. If software wants a pull-up or drive-low step between tri-state and drive-high, it must write those steps itself.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is low, and right after it is released, the direction and output-data registers read zero, and pad_oe, pad_out and pad_pu are all zero.
- R2: A write to address 1 (direction) or address 2 (output data) loads bus_wdata on the next rising edge. Reading the same address returns the stored value.
- R3: A write to address 0 inverts each output-data bit whose bus_wdata bit is 1 and leaves bits written 0 unchanged, whatever the direction bits are. The direction register is not changed.
- R4: For each pin, pad_oe equals its direction bit. pad_out equals its data bit while the pin is an output and is 0 while it is an input.
- R5: For each pin, pad_pu is 1 only when its direction bit is 0, its data bit is 1 and pullup_off is 0. In all other cases pad_pu is 0, so it is never 1 while the pin is an output.
- R6: Reading address 0 returns, for every bit, the pad_in level sampled at the most recent rising edge, whatever the direction bits are. A pad change made while the clock is low shows up on bus_rdata just after the next rising edge, and not before it.
- R7: Going from tri-state to drive-high takes one data write followed by one direction write. The pads show pull-up after the first edge and drive-high after the second edge, with no extra cycle in between.
- R8: Address 3 is unmapped. Reads of it return zero, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 pin sample/toggle, 1 direction, 2 output data |
| bus_wdata | input | NPINS | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | NPINS | Read data for bus_addr, combinational |
| pad_in | input | NPINS | Raw pad levels, asynchronous to clk |
| pullup_off | input | 1 | Global pull-up disable |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output value |
| pad_pu | output | NPINS | Per-pin pull-up enable |

## Verification
The assertions assume that bus_addr, bus_we, bus_wdata and pullup_off are stable around each rising edge. They also assume that pad_in changes only while the clock is low, so the latch and flip-flop pair always delivers the level seen at the edge. The bench drives every input just after a falling edge and holds it through the following rising edge, which keeps the stimulus inside those assumptions. It then compares all outputs against its own model half a cycle later. The checker also expects the clock to run during reset, so that the synchronizer flip-flop, which has no reset, holds a defined value by the first active cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DATA = 2'd2;

  typedef struct packed {
    logic oe;
    logic val;
    logic pu;
  } pad_ctl_t;

  // Per-pin pad control from direction, data and global pull-up disable.
  function automatic pad_ctl_t pad_decode(input logic dir, input logic dat,
                                          input logic pu_off);
    pad_ctl_t c;
    c.oe  = dir;
    c.val = dir & dat;
    c.pu  = ~dir & dat & ~pu_off;
    return c;
  endfunction

  // New data-register value after a toggle write.
  function automatic logic toggle_bit(input logic cur, input logic flip);
    return cur ^ flip;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync (
  input  logic clk,
  input  logic pad_i,
  output logic lvl_o
);
  logic lat_q;

  // Transparent while the clock is low, holding while it is high.
  always_latch begin
    if (!clk) lat_q = pad_i;
  end

  always_ff @(posedge clk) begin
    lvl_o <= lat_q;
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
(
  input  logic dir_i,
  input  logic dat_i,
  input  logic pu_off_i,
  output logic oe_o,
  output logic val_o,
  output logic pu_o
);
  pad_ctl_t ctl;

  always_comb begin
    ctl   = pad_decode(dir_i, dat_i, pu_off_i);
    oe_o  = ctl.oe;
    val_o = ctl.val;
    pu_o  = ctl.pu;
  end
endmodule

// File: rtl/gpio_port_store.sv
module gpio_port_store
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_dat,
  input  logic             wr_tgl,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] dat_q
);
  logic [NPINS-1:0] dat_nxt;

  always_comb begin
    dat_nxt = dat_q;
    if (wr_dat) begin
      dat_nxt = wdata;
    end else if (wr_tgl) begin
      for (int i = 0; i < int'(NPINS); i++) dat_nxt[i] = toggle_bit(dat_q[i], wdata[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      dat_q <= dat_nxt;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  input  logic              pullup_off,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu
);
  // Named internal events for the checker.
  logic             wr_dir, wr_dat, wr_tgl;
  logic [NPINS-1:0] dir_q, dat_q, pin_q;

  assign wr_dir = bus_we && (bus_addr == ADR_DIR);
  assign wr_dat = bus_we && (bus_addr == ADR_DATA);
  assign wr_tgl = bus_we && (bus_addr == ADR_PIN);

  gpio_port_store #(.NPINS(NPINS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr_dir),
    .wr_dat (wr_dat),
    .wr_tgl (wr_tgl),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .dat_q  (dat_q)
  );

  for (genvar g = 0; g < int'(NPINS); g++) begin : g_pin
    gpio_pin_sync u_sync (
      .clk   (clk),
      .pad_i (pad_in[g]),
      .lvl_o (pin_q[g])
    );
    gpio_pad_ctrl u_ctl (
      .dir_i    (dir_q[g]),
      .dat_i    (dat_q[g]),
      .pu_off_i (pullup_off),
      .oe_o     (pad_oe[g]),
      .val_o    (pad_out[g]),
      .pu_o     (pad_pu[g])
    );
  end

  always_comb begin
    case (bus_addr)
      ADR_PIN:  bus_rdata = pin_q;
      ADR_DIR:  bus_rdata = dir_q;
      ADR_DATA: bus_rdata = dat_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_we,
  input logic [NPINS-1:0]  pad_in,
  input logic              pullup_off,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_pu,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  dat_q,
  input logic [NPINS-1:0]  pin_q
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_DIR) |=> dir_q == $past(bus_wdata));

  a_r2_dat_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_DATA) |=> dat_q == $past(bus_wdata));

  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_PIN) |=>
      (dat_q == ($past(dat_q) ^ $past(bus_wdata)) && $stable(dir_q)));

  a_r5_no_pu_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> pad_pu == '0);

  a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q == $past(pad_in));

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd3) |=> ($stable(dir_q) && $stable(dat_q)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .pad_in     (pad_in),
  .pullup_off (pullup_off),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pu     (pad_pu),
  .dir_q      (dir_q),
  .dat_q      (dat_q),
  .pin_q      (pin_q)
);

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic         pullup_off = 1'b0;
  logic [N-1:0] pad_oe, pad_out, pad_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Reference state.
  int m_dir = 0, m_dat = 0, m_pin = 0;

  always #2 clk = ~clk;

  gpio_port_regs #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pullup_off(pullup_off), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare every output with the reference for the current address.
  task automatic compare_all();
    int rd_exp;
    int pu_exp;
    pu_exp = ~m_dir & m_dat & (pullup_off ? 0 : 'hFF);
    chk("R4 pad_oe", int'(pad_oe), m_dir & 'hFF);
    chk("R4 pad_out", int'(pad_out), m_dir & m_dat & 'hFF);
    chk("R5 pad_pu", int'(pad_pu), pu_exp & 'hFF);
    case (bus_addr)
      2'd0: begin rd_exp = m_pin; chk("R6 pin read", int'(bus_rdata), rd_exp); end
      2'd1: begin rd_exp = m_dir; chk("R2 dir read", int'(bus_rdata), rd_exp); end
      2'd2: begin rd_exp = m_dat; chk("R2 data read", int'(bus_rdata), rd_exp); end
      default: chk("R8 unmapped read", int'(bus_rdata), 0);
    endcase
  endtask

  // Drive after a falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(input int a, input int wd, input bit we, input int pad, input bit puo);
    bus_addr = 2'(a); bus_wdata = N'(wd); bus_we = we; pad_in = N'(pad); pullup_off = puo;
    @(posedge clk);
    m_pin = pad & 'hFF;
    if (we) begin
      case (a)
        0: m_dat = (m_dat ^ wd) & 'hFF;
        1: m_dir = wd & 'hFF;
        2: m_dat = wd & 'hFF;
        default: ;
      endcase
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int p;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe in reset", int'(pad_oe), 0);
    chk("R1 pu in reset", int'(pad_pu), 0);
    bus_addr = 2'd2; #0.1;
    chk("R1 data in reset", int'(bus_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after reset", int'(pad_out), 0);
    bus_addr = 2'd1; #0.1;
    chk("R1 dir after reset", int'(bus_rdata), 0);

    // R2: register loads
    step(1, 'hA5, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    step(2, 'h3C, 1, 0, 0);
    step(2, 0, 0, 0, 0);

    // R3: toggle via pin address, zeros untouched, independent of direction
    step(0, 'h0F, 1, 'h55, 0);
    step(2, 0, 0, 'h55, 0);
    chk("R3 toggle result", int'(bus_rdata), 'h33);
    step(0, 'h00, 1, 'h55, 0);
    step(2, 0, 0, 'h55, 0);
    chk("R3 zero toggle no change", int'(bus_rdata), 'h33);
    step(1, 0, 0, 0, 0);
    chk("R3 dir untouched", int'(bus_rdata), 'hA5);

    // R5: pull-up combinations
    step(1, 'h00, 1, 0, 0);
    chk("R5 pu input high data", int'(pad_pu), 'h33);
    step(1, 0, 0, 0, 1);
    chk("R5 pu global off", int'(pad_pu), 0);
    step(1, 'hFF, 1, 0, 0);
    chk("R5 pu outputs", int'(pad_pu), 0);
    chk("R4 drive data", int'(pad_out), 'h33);

    // R7: tri-state to drive-high with two writes
    step(1, 'h00, 1, 0, 0);
    step(2, 'h00, 1, 0, 0);
    chk("R7 start tri-state", int'(pad_oe | pad_pu | pad_out), 0);
    step(2, 'hFF, 1, 0, 0);
    chk("R7 after data write pu", int'(pad_pu), 'hFF);
    step(1, 'hFF, 1, 0, 0);
    chk("R7 drive high oe", int'(pad_oe), 'hFF);
    chk("R7 drive high out", int'(pad_out), 'hFF);

    // R8: unmapped write ignored
    step(3, 'h12, 1, 0, 0);
    chk("R8 unmapped read", int'(bus_rdata), 0);
    step(1, 0, 0, 0, 0);
    chk("R8 dir unchanged", int'(bus_rdata), 'hFF);
    step(2, 0, 0, 0, 0);
    chk("R8 data unchanged", int'(bus_rdata), 'hFF);

    // R6: latency, regardless of direction
    step(0, 0, 0, 'h00, 0);
    pad_in = 8'h9E; #0.5;
    chk("R6 not yet visible", int'(bus_rdata), 0);
    @(posedge clk); m_pin = 'h9E; #0.5;
    chk("R6 visible after edge", int'(bus_rdata), 'h9E);
    @(negedge clk);

    // Mixed random traffic
    for (int k = 0; k < 300; k++) begin
      p = int'($urandom_range(0, 255));
      step(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
           bit'($urandom_range(0, 1)), p, bit'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule